// File: doc/BRIEF.md
# Sign-First Successive Approximation Sequencer

This block is the digital search engine of a converter that produces twelve magnitude bits plus a sign. A single-cycle start strobe begins a conversion. The first step decides polarity by comparing the held sample against ground. A binary search then resolves the magnitude from the most significant trial bit down to the least, one bit per clock. The block drives a trial code toward an external DAC and reads back one comparator bit in every step.

When the search ends, the sign and magnitude are recombined into a 13-bit two's complement word. That word is placed in an output register, and a one-cycle done strobe is raised with it. For a negative input, the comparator reports distance from zero, so the magnitude is negated to form the code. A negative sign with a zero magnitude gives the most negative code. The DAC, the comparator and any correction arithmetic sit outside the block.

Top module: `sar_sign_first`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `done_o` and `sign_step_o` are 0, and `trial_o` and `result_o` are all zeros.
- R2: On the cycle after a start is sampled, `sign_step_o` is 1 and `trial_o` is all zeros. This is the polarity step.
- R3: A comparator value of 1 in the polarity step makes `polarity_o` 0, meaning positive. A value of 0 makes it 1, meaning negative. `polarity_o` then holds until the next start.
- R4: The cycle after the polarity step, `trial_o` is 0x800: the top bit set and every lower bit clear.
- R5: In each magnitude step with bit i under test, a comparator value of 1 keeps bit i and 0 clears it. Bit i-1 is set for the next step. The bits above i keep their decided values, and the bits below i-1 stay 0.
- R6: `done_o` is high for exactly one cycle. It first reads 1 after the 14th rising edge that follows the edge sampling start: 13 compare edges and one latch edge.
- R7: A positive outcome gives `result_o` = {0, magnitude}, with bit 12 as the sign and bits 11..0 as the magnitude, bit 11 the MSB.
- R8: A negative outcome gives `result_o` = {1, (-magnitude) mod 4096}. Magnitude 1 gives 0x1FFF, magnitude 4095 gives 0x1001, and magnitude 0 gives 0x1000.
- R9: `result_o` changes only on the cycle `done_o` rises. It holds its value between done strobes.
- R10: A start sampled while a conversion runs abandons that conversion without a done strobe. The new one restarts from the polarity step.
- R11: `busy_o` is 1 from the cycle after start until the cycle `done_o` rises. It is 0 whenever `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle conversion start strobe |
| cmp_i | input | 1 | Comparator decision for the current step |
| busy_o | output | 1 | Conversion in progress |
| sign_step_o | output | 1 | Polarity step active (DAC at zero) |
| polarity_o | output | 1 | Decided sign, 1 = negative |
| trial_o | output | 12 | Trial magnitude code to the DAC |
| done_o | output | 1 | One-cycle result-valid strobe |
| result_o | output | 13 | Two's complement result |

## Verification
A comparator model answers from a target code. The targets are zero, one, full positive scale, an alternating bit pattern, minus one, minus full scale and the most negative code. Together they separate the positive path from the negation path and expose the zero-magnitude wrap. A second stimulus drives the comparator bit by bit from a fixed pattern and checks the trial code at every step, which shows keep-versus-clear and the set-next-bit rule. A restart in mid-conversion and a hold period with a changing comparator confirm that abort resets the step count and that the result register is touched only at the latch step.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SAR_IDLE  = 2'd0,
        SAR_SIGN  = 2'd1,
        SAR_BITS  = 2'd2,
        SAR_LATCH = 2'd3
    } sar_phase_e;

endpackage

// File: rtl/sar_step_seq.sv
module sar_step_seq
    import sar_pkg::*;
#(
    parameter  int MAG_W = 12,
    localparam int IDX_W = $clog2(MAG_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output sar_phase_e       phase_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAG_W - 1);

    typedef struct packed {
        sar_phase_e       phase;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            SAR_IDLE: ;
            SAR_SIGN: begin
                s_d.phase = SAR_BITS;
                s_d.idx   = IDX_TOP;
            end
            SAR_BITS: begin
                if (s_q.idx == '0) begin
                    s_d.phase = SAR_LATCH;
                end else begin
                    s_d.idx = s_q.idx - 1'b1;
                end
            end
            SAR_LATCH: s_d.phase = SAR_IDLE;
            default:   s_d.phase = SAR_IDLE;
        endcase
        if (start_i) begin
            s_d.phase = SAR_SIGN;
            s_d.idx   = IDX_TOP;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: SAR_IDLE, idx: IDX_TOP};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign idx_o   = s_q.idx;

    // R10: a start always leads into the polarity step
    p_restart_sign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (phase_o == SAR_SIGN));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_pkg::*;
#(
    parameter  int MAG_W = 12,
    localparam int IDX_W = $clog2(MAG_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  sar_phase_e       phase_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cmp_i,
    output logic [MAG_W-1:0] trial_o,
    output logic             polarity_o
);

    typedef struct packed {
        logic [MAG_W-1:0] trial;
        logic             pol;
    } trial_t;

    trial_t t_d, t_q;

    logic [MAG_W-1:0] is_cur;
    logic [MAG_W-1:0] is_nxt;
    logic [MAG_W-1:0] bit_step;

    for (genvar i = 0; i < MAG_W; i++) begin : g_bit
        assign is_cur[i] = (idx_i == IDX_W'(i));
        if (i < MAG_W - 1) begin : g_below
            assign is_nxt[i] = is_cur[i+1];
        end else begin : g_top
            assign is_nxt[i] = 1'b0;
        end
        assign bit_step[i] = is_cur[i] ? cmp_i : (is_nxt[i] | t_q.trial[i]);
    end

    always_comb begin
        t_d = t_q;
        unique case (phase_i)
            SAR_SIGN: begin
                t_d.pol   = ~cmp_i;
                t_d.trial = {1'b1, {(MAG_W-1){1'b0}}};
            end
            SAR_BITS: t_d.trial = bit_step;
            default:  ;
        endcase
        if (start_i) begin
            t_d.trial = '0;
            t_d.pol   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign trial_o    = t_q.trial;
    assign polarity_o = t_q.pol;

    // R3: sign is frozen through the magnitude search
    p_polarity_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == SAR_BITS && !start_i) |=> $stable(polarity_o));

endmodule

// File: rtl/sar_code_fmt.sv
module sar_code_fmt #(
    parameter int MAG_W = 12
) (
    input  logic             neg_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W:0]   code_o
);

    logic [MAG_W-1:0] mag_neg;

    always_comb begin
        mag_neg = (~mag_i) + 1'b1;
        code_o  = neg_i ? {1'b1, mag_neg} : {1'b0, mag_i};
    end

endmodule

// File: rtl/sar_sign_first.sv
module sar_sign_first
    import sar_pkg::*;
#(
    parameter  int MAG_W = 12,
    localparam int IDX_W = $clog2(MAG_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             sign_step_o,
    output logic             polarity_o,
    output logic [MAG_W-1:0] trial_o,
    output logic             done_o,
    output logic [MAG_W:0]   result_o
);

    sar_phase_e       phase;
    logic [IDX_W-1:0] idx;
    logic [MAG_W:0]   code;

    sar_step_seq #(.MAG_W(MAG_W)) i_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .phase_o (phase),
        .idx_o   (idx)
    );

    sar_trial_reg #(.MAG_W(MAG_W)) i_trial (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .phase_i    (phase),
        .idx_i      (idx),
        .cmp_i      (cmp_i),
        .trial_o    (trial_o),
        .polarity_o (polarity_o)
    );

    sar_code_fmt #(.MAG_W(MAG_W)) i_fmt (
        .neg_i  (polarity_o),
        .mag_i  (trial_o),
        .code_o (code)
    );

    typedef struct packed {
        logic [MAG_W:0] res;
        logic           done;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.done = 1'b0;
        if (phase == SAR_LATCH && !start_i) begin
            o_d.res  = code;
            o_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign busy_o      = (phase != SAR_IDLE);
    assign sign_step_o = (phase == SAR_SIGN);
    assign done_o      = o_q.done;
    assign result_o    = o_q.res;

    // R2: DAC sits at zero during the polarity step
    p_sign_trial_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sign_step_o |-> (trial_o == '0));

    // R6: done is a single-cycle strobe
    p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: result register only moves with done
    p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    // R11: never busy while done is shown
    p_busy_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8: latched sign agrees with the decided polarity
    p_sign_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o[MAG_W] == polarity_o));

endmodule

// File: tb/test_sar_sign_first.sv
module test_sar_sign_first;

    localparam int CLK_PERIOD = 10;
    localparam int MAG_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             cmp;
    logic             busy, sign_step, polarity, done;
    logic [MAG_W-1:0] trial;
    logic [MAG_W:0]   result;

    logic             model_en = 1'b1;
    logic             cmp_man  = 1'b0;
    logic             tgt_neg  = 1'b0;
    logic [MAG_W-1:0] tgt_mag  = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp = model_en ? (sign_step ? !tgt_neg : (trial <= tgt_mag)) : cmp_man;

    sar_sign_first #(.MAG_W(MAG_W)) i_sar_sign_first (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .cmp_i       (cmp),
        .busy_o      (busy),
        .sign_step_o (sign_step),
        .polarity_o  (polarity),
        .trial_o     (trial),
        .done_o      (done),
        .result_o    (result)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_target(input logic [MAG_W:0] code);
        logic [MAG_W:0] neg;
        neg     = -code;
        tgt_neg = code[MAG_W];
        tgt_mag = code[MAG_W] ? neg[MAG_W-1:0] : code[MAG_W-1:0];
    endtask

    // pulse start at a negedge; returns after the negedge following the sampling edge
    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(busy == 0 && done == 0 && sign_step == 0, "R1 flags", {busy, done, sign_step}, 0);
        check(trial == 0 && result == 0, "R1 data", {trial, result}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && trial == 0 && result == 0, "R1 after release",
              {busy, done}, 0);
    endtask

    task automatic t_convert(input logic [MAG_W:0] code, input string req);
        int seen;
        model_en = 1'b1;
        set_target(code);
        pulse_start();
        check(sign_step == 1 && trial == 0, "R2 sign step", {sign_step, trial}, 32'h1000);
        check(busy == 1, "R11 busy", busy, 1);
        seen = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) begin
                check(trial == 12'h800, "R4 first trial", trial, 32'h800);
                check(polarity == code[MAG_W], "R3 polarity", polarity, code[MAG_W]);
            end
            if (done && seen == 0) seen = k;
            if (seen != 0) break;
        end
        check(seen == 14, "R6 latency", seen, 14);
        check(result == code, req, result, code);
        check(busy == 0, "R11 idle at done", busy, 0);
        @(negedge clk);
        check(done == 0, "R6 single pulse", done, 0);
    endtask

    task automatic t_pattern(input logic [MAG_W-1:0] pat);
        logic [MAG_W-1:0] exp;
        model_en = 1'b0;
        cmp_man  = 1'b1;
        pulse_start();
        for (int i = MAG_W - 1; i >= 0; i--) begin
            @(negedge clk);
            exp = (pat >> (i + 1)) << (i + 1);
            exp[i] = 1'b1;
            check(trial == exp, "R5 trial step", trial, exp);
            cmp_man = pat[i];
        end
        @(negedge clk);
        check(trial == pat && done == 0, "R5 final trial", trial, pat);
        @(negedge clk);
        check(done == 1 && result == {1'b0, pat}, "R7 pattern result", result, {1'b0, pat});
        model_en = 1'b1;
    endtask

    task automatic t_abort();
        int seen;
        model_en = 1'b1;
        set_target(13'h0123);
        pulse_start();
        repeat (6) @(negedge clk);
        set_target(13'h1ABC);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(sign_step == 1 && trial == 0, "R10 restart in sign step", {sign_step, trial}, 32'h1000);
        seen = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (done && seen == 0) seen = k;
            if (seen != 0) break;
        end
        check(seen == 14, "R10 full latency after restart", seen, 14);
        check(result == 13'h1ABC, "R10 restart result", result, 32'h1ABC);
    endtask

    task automatic t_hold();
        logic [MAG_W:0] held;
        held = result;
        model_en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            cmp_man = k[0];
            @(negedge clk);
        end
        check(result == held && done == 0, "R9 result held", result, held);
        model_en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_convert(13'h0000, "R7 zero");
        t_convert(13'h0001, "R7 one");
        t_convert(13'h0FFF, "R7 full positive");
        t_convert(13'h0555, "R7 alternating");
        t_convert(13'h1FFF, "R8 minus one");
        t_convert(13'h1001, "R8 minus full scale");
        t_convert(13'h1000, "R8 most negative");
        t_convert(13'h1AAB, "R8 alternating negative");
        t_pattern(12'hA5C);
        t_pattern(12'h3F0);
        t_abort();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule